// File: doc/BRIEF.md
# Vectored Interrupt Priority Nesting Unit

This block ranks up to sixteen vectored interrupt slots, plus one shared level for requests that no slot claims, and keeps track of nested service. Each slot holds a configuration byte and a handler address. The configuration byte names one of 32 request lines and carries an enable flag. Slot 0 has the most urgency and slot 15 the least. Requests that fall through every slot share level 16, and their handler address comes from a separate default register.

Software reaches the block through a small word-addressed register port. Reading the acknowledge register picks the most urgent pending request that outranks the level now in service. The read returns that handler address, pushes the old level onto a per-level save stack and makes the new level current. Any write to the same register pops back to the saved level. The interrupt output is raised only when a pending request outranks the current level. The request input is the enabled, IRQ-routed status vector that a routing block upstream provides.

Top module: `vpn_nest_top`

## Requirements
- R1: After reset, or a reset mid-run, every slot configuration byte, every handler address and the default address read as zero. The current level is idle (value 17), so `irq_o` is high whenever any status bit is set.
- R2: The handler address of slot n is at byte offset 0x100+4n and its configuration byte at 0x200+4n; the default address is at 0x34. A write stores the value and a read returns it; the configuration byte reads back zero-extended.
- R3: In a configuration byte, bits 4:0 select the request line and bit 5 enables the slot. A request whose line only belongs to disabled slots is never treated as vectored.
- R4: `irq_o` is high exactly when the status vector shares a bit with the mask of the current level. The mask of level L holds the lines of enabled slots numbered below L. Level 16 holds every vectored line, and the idle level holds all lines.
- R5: A read of offset 0x30 picks the lowest level L below the current level whose mask for L+1 meets the status. It returns the handler of slot L, makes L current and saves the old level for L.
- R6: When the winning level is 16, the read returns the default address and level 16 becomes current. A vectored request can then still preempt.
- R7: A read of 0x30 with no qualifying request returns the default address and leaves the current level unchanged.
- R8: Any write to 0x30 ignores its data and restores the level saved for the current level. While idle, such a write has no effect.
- R9: Nesting works to any depth. A higher-urgency slot preempts the one in service, and releases unwind the levels in reverse order.
- R10: Rewriting a configuration byte takes effect on the masks from the next cycle, including the mask of the level already in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (acknowledges at 0x30) |
| addr_i | input | 12 | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| irq_status_i | input | 32 | Enabled, IRQ-routed request lines |
| irq_o | output | 1 | Priority-qualified interrupt request |

## Verification
The hardest state to reach is a deep nest in which the save stack holds several distinct levels at once, including the unvectored level 16 sitting beneath a vectored one. The stimulus raises requests in rising urgency between acknowledge reads, so that each read pushes a new level. It then releases step by step while leaving lower-urgency requests pending, so that `irq_o` after each pop shows which level was restored. An acknowledge read at level 0, a release while idle, and a slot reconfiguration during service complete the corner cases.

// File: rtl/vpn_pkg.sv
package vpn_pkg;
  localparam int SRC_W   = 5;
  localparam int NUM_SRC = 1 << SRC_W;

  localparam logic [11:0] HANDLER_BASE = 12'h100;
  localparam logic [11:0] CTRL_BASE    = 12'h200;
  localparam logic [11:0] ACK_OFS      = 12'h030;
  localparam logic [11:0] DEF_OFS      = 12'h034;

  typedef struct packed {
    logic [1:0]       spare;
    logic             en;
    logic [SRC_W-1:0] src;
  } slot_cfg_t;
endpackage

// File: rtl/vpn_slot_file.sv
module vpn_slot_file
  import vpn_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 12
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 wr_en_i,
  input  logic [ADDR_W-1:0]                    addr_i,
  input  logic [DATA_W-1:0]                    wdata_i,
  output logic [NUM_SLOTS-1:0]                 slot_en_o,
  output logic [NUM_SLOTS-1:0][SRC_W-1:0]      slot_src_o,
  output logic [NUM_SLOTS-1:0][DATA_W-1:0]     handler_o,
  output logic [DATA_W-1:0]                    def_addr_o,
  output logic [DATA_W-1:0]                    cfg_rdata_o
);
  slot_cfg_t [NUM_SLOTS-1:0]  cfg_q;
  logic [NUM_SLOTS-1:0][DATA_W-1:0] hdl_q;
  logic [DATA_W-1:0]          def_q;

  for (genvar n = 0; n < NUM_SLOTS; n++) begin : g_slot
    localparam logic [ADDR_W-1:0] CFG_A = ADDR_W'(int'(CTRL_BASE) + 4 * n);
    localparam logic [ADDR_W-1:0] HDL_A = ADDR_W'(int'(HANDLER_BASE) + 4 * n);
    logic cfg_we, hdl_we;
    assign cfg_we = wr_en_i && (addr_i == CFG_A);
    assign hdl_we = wr_en_i && (addr_i == HDL_A);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cfg_q[n] <= '0;
        hdl_q[n] <= '0;
      end else begin
        if (cfg_we) cfg_q[n] <= slot_cfg_t'(wdata_i[7:0]);
        if (hdl_we) hdl_q[n] <= wdata_i;
      end
    end

    assign slot_en_o[n]  = cfg_q[n].en;
    assign slot_src_o[n] = cfg_q[n].src;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) def_q <= '0;
    else if (wr_en_i && addr_i == ADDR_W'(DEF_OFS)) def_q <= wdata_i;
  end

  assign handler_o  = hdl_q;
  assign def_addr_o = def_q;

  always_comb begin
    cfg_rdata_o = '0;
    if (addr_i == ADDR_W'(DEF_OFS)) cfg_rdata_o = def_q;
    for (int n = 0; n < NUM_SLOTS; n++) begin
      if (addr_i == ADDR_W'(int'(HANDLER_BASE) + 4 * n)) cfg_rdata_o = hdl_q[n];
      if (addr_i == ADDR_W'(int'(CTRL_BASE) + 4 * n))
        cfg_rdata_o = DATA_W'(cfg_q[n]);
    end
  end
endmodule

// File: rtl/vpn_mask_gen.sv
module vpn_mask_gen
  import vpn_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  localparam int NUM_MASK = NUM_SLOTS + 2
) (
  input  logic [NUM_SLOTS-1:0]             slot_en_i,
  input  logic [NUM_SLOTS-1:0][SRC_W-1:0]  slot_src_i,
  output logic [NUM_MASK-1:0][NUM_SRC-1:0] mask_o
);
  logic [NUM_SLOTS-1:0][NUM_SRC-1:0] line_dec;
  logic [NUM_SLOTS:0][NUM_SRC-1:0]   prefix;

  assign prefix[0] = '0;

  // prefix[L] = lines owned by enabled slots below L
  for (genvar l = 0; l < NUM_SLOTS; l++) begin : g_dec
    always_comb begin
      line_dec[l] = '0;
      if (slot_en_i[l]) line_dec[l][slot_src_i[l]] = 1'b1;
    end
    assign prefix[l+1] = prefix[l] | line_dec[l];
  end

  for (genvar l = 0; l <= NUM_SLOTS; l++) begin : g_out
    assign mask_o[l] = prefix[l];
  end
  assign mask_o[NUM_SLOTS+1] = '1;
endmodule

// File: rtl/vpn_prio_search.sv
module vpn_prio_search
  import vpn_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  localparam int NUM_MASK = NUM_SLOTS + 2,
  localparam int LVL_W    = $clog2(NUM_SLOTS + 2)
) (
  input  logic [NUM_MASK-1:0][NUM_SRC-1:0] mask_i,
  input  logic [NUM_SRC-1:0]               status_i,
  input  logic [LVL_W-1:0]                 cur_lvl_i,
  output logic                             hit_o,
  output logic [LVL_W-1:0]                 hit_lvl_o,
  output logic                             irq_o
);
  localparam logic [LVL_W-1:0] IDLE = LVL_W'(NUM_SLOTS + 1);

  logic [NUM_SLOTS:0] lvl_req;

  for (genvar l = 0; l <= NUM_SLOTS; l++) begin : g_req
    assign lvl_req[l] = (LVL_W'(l) < cur_lvl_i) && |(status_i & mask_i[l+1]);
  end

  always_comb begin
    hit_o     = 1'b0;
    hit_lvl_o = IDLE;
    for (int l = NUM_SLOTS; l >= 0; l--) begin
      if (lvl_req[l]) begin
        hit_o     = 1'b1;
        hit_lvl_o = LVL_W'(l);
      end
    end
  end

  assign irq_o = |(status_i & mask_i[cur_lvl_i]);
endmodule

// File: rtl/vpn_prio_stack.sv
module vpn_prio_stack #(
  parameter int NUM_SLOTS = 16,
  localparam int NUM_LVL  = NUM_SLOTS + 1,
  localparam int LVL_W    = $clog2(NUM_SLOTS + 2)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [LVL_W-1:0] push_lvl_i,
  input  logic             pop_i,
  output logic [LVL_W-1:0] cur_lvl_o
);
  localparam logic [LVL_W-1:0] IDLE = LVL_W'(NUM_LVL);

  logic [LVL_W-1:0] cur_q;
  logic [LVL_W-1:0] save_q [NUM_LVL];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q <= IDLE;
      for (int l = 0; l < NUM_LVL; l++) save_q[l] <= IDLE;
    end else if (push_i) begin
      save_q[push_lvl_i] <= cur_q;
      cur_q              <= push_lvl_i;
    end else if (pop_i && cur_q != IDLE) begin
      cur_q <= save_q[cur_q];
    end
  end

  assign cur_lvl_o = cur_q;
endmodule

// File: rtl/vpn_nest_top.sv
module vpn_nest_top
  import vpn_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic               rd_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  input  logic [NUM_SRC-1:0] irq_status_i,
  output logic               irq_o
);
  localparam int NUM_MASK = NUM_SLOTS + 2;
  localparam int LVL_W    = $clog2(NUM_SLOTS + 2);
  localparam int IDX_W    = $clog2(NUM_SLOTS);

  logic [NUM_SLOTS-1:0]             slot_en;
  logic [NUM_SLOTS-1:0][SRC_W-1:0]  slot_src;
  logic [NUM_SLOTS-1:0][DATA_W-1:0] handler;
  logic [DATA_W-1:0]                def_addr, cfg_rdata, ack_rdata;
  logic [NUM_MASK-1:0][NUM_SRC-1:0] mask;
  logic                             srch_hit, ack_sel, ack_rd, ack_wr;
  logic [LVL_W-1:0]                 srch_lvl, cur_lvl;

  assign ack_sel = (addr_i == ADDR_W'(ACK_OFS));
  assign ack_rd  = rd_en_i && ack_sel;
  assign ack_wr  = wr_en_i && ack_sel;

  vpn_slot_file #(.NUM_SLOTS(NUM_SLOTS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_slots (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i,
    .slot_en_o(slot_en), .slot_src_o(slot_src), .handler_o(handler),
    .def_addr_o(def_addr), .cfg_rdata_o(cfg_rdata)
  );

  vpn_mask_gen #(.NUM_SLOTS(NUM_SLOTS)) u_mask (
    .slot_en_i(slot_en), .slot_src_i(slot_src), .mask_o(mask)
  );

  vpn_prio_search #(.NUM_SLOTS(NUM_SLOTS)) u_search (
    .mask_i(mask), .status_i(irq_status_i), .cur_lvl_i(cur_lvl),
    .hit_o(srch_hit), .hit_lvl_o(srch_lvl), .irq_o(irq_o)
  );

  vpn_prio_stack #(.NUM_SLOTS(NUM_SLOTS)) u_stack (
    .clk_i, .rst_ni,
    .push_i(ack_rd && srch_hit), .push_lvl_i(srch_lvl),
    .pop_i(ack_wr), .cur_lvl_o(cur_lvl)
  );

  always_comb begin
    ack_rdata = def_addr;
    if (srch_hit && srch_lvl < LVL_W'(NUM_SLOTS)) ack_rdata = handler[srch_lvl[IDX_W-1:0]];
  end

  assign rdata_o = ack_sel ? ack_rdata : cfg_rdata;
endmodule

// File: rtl/vpn_nest_chk.sv
module vpn_nest_chk
  import vpn_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int ADDR_W    = 12,
  localparam int LVL_W    = $clog2(NUM_SLOTS + 2)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               rd_en_i,
  input logic               wr_en_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic [NUM_SRC-1:0] irq_status_i,
  input logic               irq_o,
  input logic [LVL_W-1:0]   cur_lvl,
  input logic               hit,
  input logic [LVL_W-1:0]   hit_lvl
);
  localparam logic [LVL_W-1:0] IDLE = LVL_W'(NUM_SLOTS + 1);
  logic ack_rd, ack_wr;
  assign ack_rd = rd_en_i && addr_i == ADDR_W'(ACK_OFS);
  assign ack_wr = wr_en_i && addr_i == ADDR_W'(ACK_OFS);

  AST_IRQ_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (|irq_status_i)); // R4
  AST_IRQ_MATCHES_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == hit); // R4
  AST_HIT_OUTRANKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |-> hit_lvl < cur_lvl); // R5
  AST_ACK_RAISES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_rd && hit) |=> cur_lvl == $past(hit_lvl)); // R5
  AST_MISS_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_rd && !hit) |=> $stable(cur_lvl)); // R7
  AST_IDLE_POP_NOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_wr && !ack_rd && cur_lvl == IDLE) |=> cur_lvl == IDLE); // R8
  AST_LVL_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cur_lvl <= IDLE); // R9
endmodule

bind vpn_nest_top vpn_nest_chk #(.NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W)) u_chk (
  .clk_i, .rst_ni, .rd_en_i, .wr_en_i, .addr_i, .irq_status_i, .irq_o,
  .cur_lvl(cur_lvl), .hit(srch_hit), .hit_lvl(srch_lvl)
);

// File: tb/vpn_nest_top_bench.sv
module vpn_nest_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] OP_W = 2'd0, OP_R = 2'd1, OP_N = 2'd2;
  localparam logic [31:0] B20 = 32'h0010_0000, B12 = 32'h0000_1000,
                          B7 = 32'h0000_0080, B3 = 32'h0000_0008;
  localparam logic [31:0] HA0 = 32'hA000_0000, HA1 = 32'hA000_0100,
                          HA5 = 32'hA000_0500, DEFA = 32'hD000_0000;

  typedef struct packed {
    logic [1:0]  op;
    logic [11:0] addr;
    logic [31:0] wdata;
    logic [31:0] status;
    logic [31:0] exp_rd;
    logic        exp_irq;
    logic [7:0]  tag;
  } vec_t;

  localparam int NV = 37;
  localparam vec_t [0:NV-1] TBL = '{
    '{OP_W, 12'h200, 32'h23, 32'h0, 32'h0, 1'b0, 8'd2},      // R2 slot0 line3
    '{OP_W, 12'h204, 32'h27, 32'h0, 32'h0, 1'b0, 8'd2},      // R2 slot1 line7
    '{OP_W, 12'h208, 32'h0C, 32'h0, 32'h0, 1'b0, 8'd3},      // R3 slot2 disabled
    '{OP_W, 12'h214, 32'h34, 32'h0, 32'h0, 1'b0, 8'd2},      // R2 slot5 line20
    '{OP_W, 12'h100, HA0, 32'h0, 32'h0, 1'b0, 8'd2},
    '{OP_W, 12'h104, HA1, 32'h0, 32'h0, 1'b0, 8'd2},
    '{OP_W, 12'h114, HA5, 32'h0, 32'h0, 1'b0, 8'd2},
    '{OP_W, 12'h034, DEFA, 32'h0, 32'h0, 1'b0, 8'd2},
    '{OP_R, 12'h200, 32'h0, 32'h0, 32'h23, 1'b0, 8'd2},      // R2
    '{OP_R, 12'h114, 32'h0, 32'h0, HA5, 1'b0, 8'd2},         // R2
    '{OP_R, 12'h034, 32'h0, 32'h0, DEFA, 1'b0, 8'd2},        // R2
    '{OP_R, 12'h208, 32'h0, 32'h0, 32'h0C, 1'b0, 8'd3},      // R3
    '{OP_N, 12'h000, 32'h0, B20, 32'h0, 1'b1, 8'd4},         // R4 idle
    '{OP_R, 12'h030, 32'h0, B20, HA5, 1'b0, 8'd5},           // R5 -> lvl5
    '{OP_N, 12'h000, 32'h0, B20|B12, 32'h0, 1'b0, 8'd3},     // R3
    '{OP_N, 12'h000, 32'h0, B20|B7, 32'h0, 1'b1, 8'd9},      // R9 preempt
    '{OP_R, 12'h030, 32'h0, B20|B7, HA1, 1'b0, 8'd9},        // R9 -> lvl1
    '{OP_N, 12'h000, 32'h0, B20|B7|B3, 32'h0, 1'b1, 8'd9},
    '{OP_R, 12'h030, 32'h0, B20|B7|B3, HA0, 1'b0, 8'd5},     // R5 -> lvl0
    '{OP_R, 12'h030, 32'h0, B20|B7|B3, DEFA, 1'b0, 8'd7},    // R7 miss at lvl0
    '{OP_W, 12'h030, 32'hFFFF_FFFF, B20|B7|B3, 32'h0, 1'b1, 8'd8}, // R8 -> lvl1
    '{OP_W, 12'h030, 32'h0, B20|B7|B3, 32'h0, 1'b1, 8'd8},   // R8 -> lvl5
    '{OP_W, 12'h030, 32'h0, 32'h0, 32'h0, 1'b0, 8'd8},       // R8 -> idle
    '{OP_N, 12'h000, 32'h0, B20, 32'h0, 1'b1, 8'd8},
    '{OP_R, 12'h030, 32'h0, B12, DEFA, 1'b0, 8'd6},          // R6 -> lvl16
    '{OP_N, 12'h000, 32'h0, B12|B20, 32'h0, 1'b1, 8'd6},     // R6
    '{OP_R, 12'h030, 32'h0, B12|B20, HA5, 1'b0, 8'd9},       // R9 16 -> 5
    '{OP_W, 12'h030, 32'h0, B12|B20, 32'h0, 1'b1, 8'd8},     // R8 -> 16
    '{OP_W, 12'h030, 32'h0, B12, 32'h0, 1'b1, 8'd8},         // R8 -> idle
    '{OP_W, 12'h030, 32'h0, B12, 32'h0, 1'b1, 8'd8},         // R8 idle nop
    '{OP_R, 12'h030, 32'h0, 32'h0, DEFA, 1'b0, 8'd7},        // R7
    '{OP_N, 12'h000, 32'h0, B20, 32'h0, 1'b1, 8'd7},         // R7 still idle
    '{OP_R, 12'h030, 32'h0, B20, HA5, 1'b0, 8'd5},
    '{OP_N, 12'h000, 32'h0, B3|B20, 32'h0, 1'b1, 8'd10},     // R10
    '{OP_W, 12'h200, 32'h00, B3|B20, 32'h0, 1'b0, 8'd10},    // R10 slot0 off
    '{OP_W, 12'h210, 32'h23, B3|B20, 32'h0, 1'b1, 8'd10},    // R10 slot4 line3
    '{OP_W, 12'h030, 32'h0, 32'h0, 32'h0, 1'b0, 8'd8}
  };

  logic clk = 1'b0, rst_n = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, status = '0, rdata;
  logic irq;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vpn_nest_top u_vpn_nest_top (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr), .rd_en_i(rd), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_status_i(status), .irq_o(irq)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input int tag,
                     input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(input vec_t v, input int idx);
    @(negedge clk);
    status = v.status; addr = v.addr; wdata = v.wdata;
    wr = (v.op == OP_W); rd = (v.op == OP_R);
    #1;
    if (v.op == OP_R) chk(rdata, v.exp_rd, int'(v.tag), $sformatf("rdata step %0d", idx));
    @(negedge clk);
    wr = 1'b0; rd = 1'b0;
    chk({31'b0, irq}, {31'b0, v.exp_irq}, int'(v.tag), $sformatf("irq step %0d", idx));
  endtask

  task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input int tag);
    @(negedge clk);
    addr = a; rd = 1'b1;
    #1 chk(rdata, exp, tag, $sformatf("read %h", a));
    @(negedge clk);
    rd = 1'b0;
  endtask

  initial begin
    // R1 reset state
    status = 32'h8000_0000;
    repeat (3) @(negedge clk);
    chk({31'b0, irq}, 32'h1, 1, "irq in reset");
    rst_n = 1'b1;
    for (int n = 0; n < 16; n++) begin
      rd_chk(12'(12'h200 + 4 * n), 32'h0, 1);
      rd_chk(12'(12'h100 + 4 * n), 32'h0, 1);
    end
    rd_chk(12'h034, 32'h0, 1);
    status = 32'h0;
    rd_chk(12'h030, 32'h0, 1);

    for (int i = 0; i < NV; i++) step(TBL[i], i);

    // R1 reset mid-service
    step('{OP_W, 12'h200, 32'h23, 32'h0, 32'h0, 1'b0, 8'd1}, 100);
    step('{OP_W, 12'h100, HA0, 32'h0, 32'h0, 1'b0, 8'd1}, 101);
    step('{OP_R, 12'h030, 32'h0, B3, HA0, 1'b0, 8'd1}, 102);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    chk({31'b0, irq}, 32'h1, 1, "irq idle after reset");
    rd_chk(12'h100, 32'h0, 1);
    rd_chk(12'h200, 32'h0, 1);
    rd_chk(12'h214, 32'h0, 1);
    rd_chk(12'h034, 32'h0, 1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R9 watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule